// File: doc/BRIEF.md
# SDRAM Idle Power-Down Controller

This block drives the clock-enable line of an SDRAM interface. It decides when the interface has nothing left to do. It counts how long that quiet spell lasts. When the quiet spell reaches a programmed length, it drops clock-enable and the memory enters power-down.

The interface is quiet only when three things hold at once: the command queue is empty, no command delay is still running, and the read-return queue has drained. Any break in that condition clears the count.

When a command lands in the queue during power-down, clock-enable rises in the same cycle. The controller then keeps command issue blocked for a programmable number of cycles, so the device has time to settle before it sees traffic. A programmed period of zero turns automatic power-down off.

Top module: `sdram_idle_pd`

## Requirements
- R1: After reset, `cke` is 1, `pd_active` is 0 and `issue_ok` is 1.
- R2: While `cmd_delay_busy` is 1, the idle count does not advance and power-down is not entered.
- R3: While `rd_fifo_empty` is 0, the idle count does not advance and power-down is not entered.
- R4: Any cycle that is not idle clears the idle count to zero. Idle means `cmd_fifo_empty`=1, `rd_fifo_empty`=1 and `cmd_delay_busy`=0. A later idle spell therefore needs the full period again.
- R5: With `idle_period`=P>0, power-down is entered on the P-th consecutive rising edge that samples idle. On entry, `pd_active` becomes 1 and `cke` becomes 0.
- R6: When `idle_period` is 0, power-down is never entered.
- R7: `cke` is 1 in every cycle in which `cmd_fifo_empty` is 0, including the very cycle in which a command arrives during power-down.
- R8: In power-down, the first rising edge that samples `cmd_fifo_empty`=0 clears `pd_active`.
- R9: After that exit edge, `issue_ok` stays 0 for `wake_holdoff`=H further cycles and returns to 1 on the H-th rising edge after the exit edge. When H is 0, it returns to 1 right at the exit edge.
- R10: `issue_ok` is 0 whenever `pd_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_fifo_empty | input | 1 | Command queue holds no entries |
| rd_fifo_empty | input | 1 | Read-return queue has drained |
| cmd_delay_busy | input | 1 | A command timing delay is still running |
| idle_period | input | PRD_W | Idle cycles before power-down (0 disables) |
| wake_holdoff | input | HOLD_W | Cycles of blocked issue after exit |
| cke | output | 1 | SDRAM clock enable |
| pd_active | output | 1 | Device is in power-down |
| issue_ok | output | 1 | Command issue is permitted |

## Verification
The assertions check several rules on every cycle:
- `cke` is high whenever the command queue is non-empty.
- Power-down is never entered unless the previous cycle was idle with a non-zero period.
- A pending command always ends power-down on the next edge.
- `issue_ok` is always low during power-down.

The exact entry cycle and the count restart after a broken idle spell depend on counting whole sequences of cycles, so only the bench scenarios can show them. The same holds for the length of the hold-off window.

// File: rtl/sdram_idle_pd.sv
module sdram_idle_pd #(
  parameter int PRD_W  = 16,
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fifo_empty,
  input  logic              rd_fifo_empty,
  input  logic              cmd_delay_busy,
  input  logic [PRD_W-1:0]  idle_period,
  input  logic [HOLD_W-1:0] wake_holdoff,
  output logic              cke,
  output logic              pd_active,
  output logic              issue_ok
);
  localparam int CW = PRD_W + 1;

  logic [PRD_W-1:0]  idle_cnt;
  logic [HOLD_W-1:0] hold_cnt;
  logic              pd_q;
  logic              idle;
  logic [CW-1:0]     cnt_nxt;

  assign idle    = cmd_fifo_empty && rd_fifo_empty && !cmd_delay_busy;
  assign cnt_nxt = {1'b0, idle_cnt} + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      hold_cnt <= '0;
      pd_q     <= 1'b0;
    end else if (pd_q) begin
      idle_cnt <= '0;
      if (!cmd_fifo_empty) begin
        pd_q     <= 1'b0;
        hold_cnt <= wake_holdoff;
      end
    end else begin
      if (hold_cnt != '0) hold_cnt <= hold_cnt - HOLD_W'(1);
      if (!idle || idle_period == '0) begin
        idle_cnt <= '0;
      end else if (cnt_nxt >= {1'b0, idle_period}) begin
        pd_q     <= 1'b1;
        idle_cnt <= '0;
        hold_cnt <= '0;
      end else begin
        idle_cnt <= cnt_nxt[PRD_W-1:0];
      end
    end
  end

  assign pd_active = pd_q;
  assign cke       = !pd_q || !cmd_fifo_empty;
  assign issue_ok  = !pd_q && hold_cnt == '0;
endmodule

// File: rtl/sdram_idle_pd_chk.sv
module sdram_idle_pd_chk #(
  parameter int PRD_W  = 16,
  parameter int HOLD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_fifo_empty,
  input logic              rd_fifo_empty,
  input logic              cmd_delay_busy,
  input logic [PRD_W-1:0]  idle_period,
  input logic [HOLD_W-1:0] wake_holdoff,
  input logic              cke,
  input logic              pd_active,
  input logic              issue_ok
);
  // R7
  cke_on_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_fifo_empty |-> cke);

  // R5
  cke_low_means_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> pd_active);

  // R2
  entry_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_active) |-> ($past(cmd_fifo_empty) && $past(rd_fifo_empty) &&
                          !$past(cmd_delay_busy) && $past(idle_period) != '0));

  // R6
  zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_period == '0 && !pd_active) |=> !pd_active);

  // R8
  exit_on_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && !cmd_fifo_empty) |=> !pd_active);

  // R10
  no_issue_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> !issue_ok);
endmodule

bind sdram_idle_pd sdram_idle_pd_chk #(.PRD_W(PRD_W), .HOLD_W(HOLD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_fifo_empty(cmd_fifo_empty),
  .rd_fifo_empty(rd_fifo_empty), .cmd_delay_busy(cmd_delay_busy),
  .idle_period(idle_period), .wake_holdoff(wake_holdoff),
  .cke(cke), .pd_active(pd_active), .issue_ok(issue_ok));

// File: tb/sdram_idle_pd_tb.sv
module sdram_idle_pd_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_fifo_empty = 1, rd_fifo_empty = 1, cmd_delay_busy = 0;
  logic [15:0] idle_period = 16'd4;
  logic [3:0]  wake_holdoff = 4'd0;
  logic cke, pd_active, issue_ok;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sdram_idle_pd dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_fifo_empty(cmd_fifo_empty),
    .rd_fifo_empty(rd_fifo_empty), .cmd_delay_busy(cmd_delay_busy),
    .idle_period(idle_period), .wake_holdoff(wake_holdoff),
    .cke(cke), .pd_active(pd_active), .issue_ok(issue_ok));

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cmd_fifo_empty = 1; rd_fifo_empty = 1; cmd_delay_busy = 0;
    tick(2);
    rst_n = 1;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 0; tick(2);
    check("R1", "cke", cke, 1);
    check("R1", "pd_active", pd_active, 0);
    check("R1", "issue_ok", issue_ok, 1);
    rst_n = 1;
  endtask

  task automatic t_entry();
    do_reset(); idle_period = 16'd4;
    tick(3);
    check("R5", "pd before period", pd_active, 0);
    tick(1);
    check("R5", "pd at period", pd_active, 1);
    check("R5", "cke at period", cke, 0);
    check("R10", "issue in pd", issue_ok, 0);
  endtask

  task automatic t_delay_block();
    do_reset(); idle_period = 16'd2; cmd_delay_busy = 1;
    tick(6);
    check("R2", "pd while delay busy", pd_active, 0);
    cmd_delay_busy = 0; tick(1);
    check("R2", "pd one edge after delay", pd_active, 0);
    tick(1);
    check("R2", "pd after delay period", pd_active, 1);
  endtask

  task automatic t_rd_block();
    do_reset(); idle_period = 16'd2; rd_fifo_empty = 0;
    tick(6);
    check("R3", "pd while read queue busy", pd_active, 0);
    check("R3", "cke while read queue busy", cke, 1);
    rd_fifo_empty = 1; tick(2);
    check("R3", "pd after drain", pd_active, 1);
  endtask

  task automatic t_idle_loss();
    do_reset(); idle_period = 16'd4;
    tick(3);
    cmd_delay_busy = 1; tick(1);
    cmd_delay_busy = 0; tick(3);
    check("R4", "pd after restart short", pd_active, 0);
    tick(1);
    check("R4", "pd after full restart", pd_active, 1);
  endtask

  task automatic t_zero();
    do_reset(); idle_period = 16'd0;
    tick(40);
    check("R6", "pd with zero period", pd_active, 0);
    check("R6", "cke with zero period", cke, 1);
  endtask

  task automatic t_exit(input logic [3:0] h);
    do_reset(); idle_period = 16'd3; wake_holdoff = h;
    tick(3);
    check("R5", "pd before exit", pd_active, 1);
    cmd_fifo_empty = 0; #1;
    check("R7", "cke same cycle as work", cke, 1);
    check("R10", "issue before exit edge", issue_ok, 0);
    tick(1);
    check("R8", "pd after exit edge", pd_active, 0);
    if (h == 0) begin
      check("R9", "issue with zero holdoff", issue_ok, 1);
    end else begin
      check("R9", "issue at exit edge", issue_ok, 0);
      if (h > 1) tick(h - 1);
      check("R9", "issue last holdoff cycle", issue_ok, 0);
      tick(1);
      check("R9", "issue after holdoff", issue_ok, 1);
    end
    check("R7", "cke while work pending", cke, 1);
    cmd_fifo_empty = 1;
  endtask

  initial begin
    t_reset();
    t_entry();
    t_delay_block();
    t_rd_block();
    t_idle_loss();
    t_zero();
    t_exit(4'd3);
    t_exit(4'd0);
    t_exit(4'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule